// File: doc/BRIEF.md
# LFSR-Sequenced Trace Buffer Pointer Unit

This block holds the write and read addresses of a trace buffer that lives in an external SRAM of 2^15 words. Each address is a 15-bit pointer. The pointers do not count in binary. They walk a maximal-length linear feedback shift register sequence, so each step needs only a shift and one XOR. The sequence covers every nonzero code, and the all-zero code is never used. Because the pointers cannot be subtracted to find the fill level, a separate occupancy counter produces the empty, almost-full and full flags.

A trigger is captured on the clock and qualified by the unit's select input. The access mode is captured together with it. In the cycle after capture, the address output shows the pointer for the captured mode, so the external access uses that address. At the end of that cycle the pointer moves to its successor. In record mode the write pointer is used and advanced. In extract mode the read pointer is used and advanced. The almost-full flag warns upstream logic early enough to stall the trace source before the buffer overflows.

Top module: `lfsr_fifo_ptr`

## Requirements
- R1: While rst_ni is low, both pointers hold the seed 15'h0001, the occupancy is 0, empty_o is 1, and full_o and almost_full_o are 0. The captured mode resets to record, so addr_o shows 15'h0001.
- R2: At each rising clock edge the unit registers trig_i AND cs_i. A trigger therefore acts in the cycle after the edge that captured it. A trigger seen while cs_i is low has no effect on the pointers or the flags.
- R3: mode_i is registered at the same edge as the trigger (0 = record, 1 = extract). In the same cycle, addr_o shows the write pointer when the captured mode is record and the read pointer when it is extract.
- R4: An accepted record trigger moves the write pointer to its successor at the end of its cycle and leaves the read pointer unchanged.
- R5: An accepted extract trigger moves the read pointer to its successor at the end of its cycle and leaves the write pointer unchanged.
- R6: The successor of pointer p is {p[13:0], p[14]^p[13]}. A pointer is never zero, and it returns to the seed after exactly 32767 advances.
- R7: The occupancy rises by one on each accepted record trigger and falls by one on each accepted extract trigger. empty_o is 1 exactly when the occupancy is 0.
- R8: full_o is 1 exactly when the occupancy is 32767. full_o and empty_o are never both 1.
- R9: almost_full_o is 1 exactly when the occupancy is at least 32703, which is 64 below full.
- R10: A record trigger while full, or an extract trigger while empty, is dropped. The pointer and the occupancy are left unchanged.
- R11: Pulling rst_ni low at any time returns the unit to the R1 state without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Access trigger, one access per cycle it is high |
| cs_i | input | 1 | Unit select; qualifies trig_i |
| mode_i | input | 1 | 0 = record (write pointer), 1 = extract (read pointer) |
| addr_o | output | 15 | SRAM address from the selected pointer |
| empty_o | output | 1 | Occupancy is zero |
| almost_full_o | output | 1 | Occupancy at or above the warning threshold |
| full_o | output | 1 | Occupancy at capacity |

## Verification
Two things can land in the same cycle. A trigger can arrive on the very edge where the mode input changes, and a trigger can arrive while the occupancy sits at a boundary. The stimulus table flips the mode between record and extract on consecutive triggered cycles. At each step the address is compared against the pointer that a bench-side model selects for the mode captured with that trigger. The long fill and drain runs send a trigger in the cycle where the occupancy reaches full or empty. They check that the flag seen in that cycle gates the access, so the pointer is frozen and the address is unchanged on the following cycle.

// File: rtl/lfsr_fifo_pkg.sv
package lfsr_fifo_pkg;
  typedef enum logic {
    MODE_RECORD  = 1'b0,
    MODE_EXTRACT = 1'b1
  } fifo_mode_e;

  localparam int unsigned PTR_WRITE = 0;
  localparam int unsigned PTR_READ  = 1;
  localparam int unsigned NUM_PTRS  = 2;
endpackage

// File: rtl/lfsr_fifo_in_sync.sv
module lfsr_fifo_in_sync
  import lfsr_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic       cs_i,
  input  logic       mode_i,
  output logic       trig_q_o,
  output fifo_mode_e mode_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q_o <= 1'b0;
      mode_q_o <= MODE_RECORD;
    end else begin
      trig_q_o <= trig_i & cs_i;
      mode_q_o <= fifo_mode_e'(mode_i);
    end
  end
endmodule

// File: rtl/lfsr_fifo_lfsr_ptr.sv
module lfsr_fifo_lfsr_ptr #(
  parameter int unsigned     AW   = 15,
  parameter logic [AW-1:0]   TAPS = 15'h6000,
  parameter logic [AW-1:0]   SEED = 15'h0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  logic          fb;
  logic [AW-1:0] ptr_d;

  // Fibonacci form: XOR of tapped bits shifts in at the LSB
  assign fb    = ^(ptr_o & TAPS);
  assign ptr_d = {ptr_o[AW-2:0], fb};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= SEED;
    else if (adv_i) ptr_o <= ptr_d;
  end
endmodule

// File: rtl/lfsr_fifo_occupancy.sv
module lfsr_fifo_occupancy #(
  parameter int unsigned AW        = 15,
  parameter int unsigned AF_MARGIN = 64,
  localparam int unsigned CW       = AW + 1,
  localparam int unsigned DEPTH    = (1 << AW) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          almost_full_o,
  output logic          full_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_AF   = CW'(DEPTH - AF_MARGIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (inc_i)   count_o <= count_o + 1'b1;
    else if (dec_i)   count_o <= count_o - 1'b1;
  end

  assign empty_o       = (count_o == '0);
  assign full_o        = (count_o == CNT_FULL);
  assign almost_full_o = (count_o >= CNT_AF);
endmodule

// File: rtl/lfsr_fifo_ptr.sv
module lfsr_fifo_ptr
  import lfsr_fifo_pkg::*;
#(
  parameter int unsigned   AW        = 15,
  parameter logic [AW-1:0] TAPS      = 15'h6000,
  parameter logic [AW-1:0] SEED      = 15'h0001,
  parameter int unsigned   AF_MARGIN = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          cs_i,
  input  logic          mode_i,
  output logic [AW-1:0] addr_o,
  output logic          empty_o,
  output logic          almost_full_o,
  output logic          full_o
);
  localparam int unsigned CW    = AW + 1;
  localparam int unsigned DEPTH = (1 << AW) - 1;

  logic          trig_q;
  fifo_mode_e    mode_q;
  logic          rec_go, ext_go;
  logic [NUM_PTRS-1:0] adv;
  logic [AW-1:0] ptr_q [NUM_PTRS];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  lfsr_fifo_in_sync u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig_i),
    .cs_i     (cs_i),
    .mode_i   (mode_i),
    .trig_q_o (trig_q),
    .mode_q_o (mode_q)
  );

  // Flags gate the access in the trigger cycle
  assign rec_go = trig_q && (mode_q == MODE_RECORD)  && !full_o;
  assign ext_go = trig_q && (mode_q == MODE_EXTRACT) && !empty_o;

  assign adv[PTR_WRITE] = rec_go;
  assign adv[PTR_READ]  = ext_go;

  for (genvar i = 0; i < NUM_PTRS; i++) begin : g_ptr
    lfsr_fifo_lfsr_ptr #(
      .AW   (AW),
      .TAPS (TAPS),
      .SEED (SEED)
    ) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (adv[i]),
      .ptr_o  (ptr_q[i])
    );
  end

  assign wr_ptr = ptr_q[PTR_WRITE];
  assign rd_ptr = ptr_q[PTR_READ];
  assign addr_o = (mode_q == MODE_EXTRACT) ? rd_ptr : wr_ptr;

  lfsr_fifo_occupancy #(
    .AW        (AW),
    .AF_MARGIN (AF_MARGIN)
  ) u_occ (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .inc_i         (rec_go),
    .dec_i         (ext_go),
    .count_o       (count),
    .empty_o       (empty_o),
    .almost_full_o (almost_full_o),
    .full_o        (full_o)
  );
endmodule

// File: rtl/lfsr_fifo_ptr_chk.sv
module lfsr_fifo_ptr_chk #(
  parameter int unsigned AW    = 15,
  parameter int unsigned CW    = 16,
  parameter int unsigned DEPTH = 32767
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          trig_q,
  input logic          mode_q,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [CW-1:0] count,
  input logic          empty_o,
  input logic          almost_full_o,
  input logic          full_o
);
  assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));

  assert_ptr_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr != '0) && (rd_ptr != '0));

  assert_full_implies_af_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> almost_full_o);

  assert_rec_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !mode_q && !full_o) |=>
      (wr_ptr != $past(wr_ptr)) && $stable(rd_ptr) && (count == $past(count) + 1'b1));

  assert_ext_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && mode_q && !empty_o) |=>
      (rd_ptr != $past(rd_ptr)) && $stable(wr_ptr) && (count == $past(count) - 1'b1));

  assert_drop_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !mode_q && full_o) |=> $stable(wr_ptr) && $stable(count));

  assert_drop_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && mode_q && empty_o) |=> $stable(rd_ptr) && $stable(count));

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_q |=> $stable(wr_ptr) && $stable(rd_ptr) && $stable(count));
endmodule

bind lfsr_fifo_ptr lfsr_fifo_ptr_chk #(
  .AW    (AW),
  .CW    (CW),
  .DEPTH (DEPTH)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trig_q        (trig_q),
  .mode_q        (mode_q),
  .wr_ptr        (wr_ptr),
  .rd_ptr        (rd_ptr),
  .count         (count),
  .empty_o       (empty_o),
  .almost_full_o (almost_full_o),
  .full_o        (full_o)
);

// File: tb/lfsr_fifo_ptr_tb_top.sv
module lfsr_fifo_ptr_tb_top;
  localparam int          AW    = 15;
  localparam int          DEPTH = 32767;
  localparam int          AF_TH = 32703;
  localparam logic [14:0] SEED  = 15'h0001;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_i = 1'b0;
  logic        cs_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic        empty_o, almost_full_o, full_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [14:0] m_wp, m_rp;
  int          m_cnt;

  typedef struct packed {
    logic t;
    logic c;
    logic m;
    logic e;  // expected empty_o in that step's cycle
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1},  // extract on empty: dropped
    '{1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b0},  // not selected
    '{1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0},  // mode flips with trigger
    '{1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1},  // dropped on empty
    '{1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b0}
  };

  lfsr_fifo_ptr dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trig_i        (trig_i),
    .cs_i          (cs_i),
    .mode_i        (mode_i),
    .addr_o        (addr_o),
    .empty_o       (empty_o),
    .almost_full_o (almost_full_o),
    .full_o        (full_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic logic [14:0] succ(input logic [14:0] p);
    return {p[13:0], p[14] ^ p[13]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wp  = SEED;
    m_rp  = SEED;
    m_cnt = 0;
  endtask

  // Drive at a negedge, check one cycle later, then apply the model update
  task automatic step(input logic t, input logic c, input logic m);
    trig_i = t;
    cs_i   = c;
    mode_i = m;
    @(negedge clk_i);
    chk("R3 R4 R5 addr", 32'(addr_o), 32'(m ? m_rp : m_wp));
    chk("R7 R8 R9 flags", {29'd0, full_o, almost_full_o, empty_o},
        {29'd0, m_cnt == DEPTH, m_cnt >= AF_TH, m_cnt == 0});
    if (t && c) begin
      if (!m && m_cnt < DEPTH) begin
        m_wp = succ(m_wp);
        m_cnt++;
      end else if (m && m_cnt > 0) begin
        m_rp = succ(m_rp);
        m_cnt--;
      end
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    #13;
    // R1: reset state
    chk("R1 addr", 32'(addr_o), 32'(SEED));
    chk("R1 flags", {29'd0, full_o, almost_full_o, empty_o}, 32'b001);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // Table walk: gating, mode alignment, drops on empty
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].t, VEC[i].c, VEC[i].m);
      chk("R7 R2 R10 table empty", 32'(empty_o), 32'(VEC[i].e));
    end

    // R11: asynchronous reset mid-run (occupancy is 1 here)
    step(1'b0, 1'b0, 1'b0);
    chk("R11 pre empty", 32'(empty_o), 32'd0);
    #1 rst_ni = 1'b0;
    #1;
    chk("R11 addr", 32'(addr_o), 32'(SEED));
    chk("R11 empty", 32'(empty_o), 32'd1);
    model_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;

    // Fill to capacity: R9 threshold and R8 full along the way
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);  // record while full: dropped
    step(1'b0, 1'b1, 1'b0);
    chk("R6 wrap write", 32'(addr_o), 32'(SEED));
    chk("R10 R8 full held", {30'd0, full_o, almost_full_o}, 32'b11);

    // Drain to empty
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);  // extract while empty: dropped
    step(1'b0, 1'b1, 1'b1);
    chk("R6 wrap read", 32'(addr_o), 32'(SEED));
    chk("R10 R7 empty held", {29'd0, full_o, almost_full_o, empty_o}, 32'b001);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule